// File: doc/BRIEF.md
# Master-Clock Enable Strobe Generator

This block turns one 48 MHz master clock into a family of single-cycle enable strobes for a system with a main processor and a sound processor. A binary divider gives strobes at 24, 12 and 6 MHz. A divide-by-three stage, which advances only on the 24 MHz strobe, gives 8 MHz. Halving that 8 MHz strobe gives a fixed 4 MHz sound-processor enable. Every output is a registered pulse one master cycle wide in the master clock domain. None of them is a derived clock.

The main-processor enable has two candidate rates. One is the 12 MHz strobe halved, which is the 6 MHz strobe. The other is the 8 MHz strobe halved, which is 4 MHz. A static jumper input picks between them, and a low jumper gives 6 MHz. The jumper is captured while reset is held. After reset a new value is adopted only on a cycle where both candidate strobes fire at once. Because of this, every interval between main pulses is exactly one of the two nominal periods, and the main strobe stays phase-aligned with the other strobes.

Top module: `ce_clock_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every enable output is low after that edge.
- R2: Counting rising edges from the first edge with `rst` low as edge 1, `en_bin[0]` (24 MHz) is high after edge n exactly when n is a multiple of 2.
- R3: `en_bin[1]` (12 MHz) is high after edge n exactly when n is a multiple of 4. `en_bin[2]` (6 MHz) is high after edge n exactly when n is a multiple of 8.
- R4: `en_phi` (8 MHz) is high after edge n exactly when n is a multiple of 6. It is only ever high together with `en_bin[0]`.
- R5: `en_sound` (4 MHz) is high after edge n exactly when n is a multiple of 12, whatever the value of `sel_slow`.
- R6: With `sel_slow` held at 0, `en_main` is high exactly when n is a multiple of 8. With `sel_slow` held at 1, `en_main` is high exactly when n is a multiple of 12.
- R7: A change on `sel_slow` is adopted only at an edge where both the 8-cycle and the 12-cycle candidate strobes fire, which is every 24 cycles by default. In between, `en_main` keeps the old rate, and every interval between two `en_main` pulses is exactly 8 or 12 cycles.
- R8: The value of `sel_slow` during reset sets the rate of `en_main` from edge 1 until the first common boundary, even if the jumper changes as reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_slow | input | 1 | Jumper: 0 selects the 6 MHz main rate, 1 selects the 4 MHz main rate |
| en_bin | output | BIN_STAGES | Binary divider strobes; bit 0 is 24 MHz, bit 1 is 12 MHz, bit 2 is 6 MHz |
| en_phi | output | 1 | 8 MHz strobe (24 MHz strobe divided by three) |
| en_sound | output | 1 | 4 MHz sound-processor enable |
| en_main | output | 1 | Main-processor enable at 6 or 4 MHz |

## Verification
The interval check on `en_main` assumes that `sel_slow` is quasi-static. It may change at any cycle, but only a changed level is ever seen, with no glitching within a cycle. The bench therefore drives the jumper only on falling edges. The bench moves it in the middle of a main period, both from fast to slow and back, and also as reset is released. It then confirms that pulses land only on the cycles the requirements give. The nesting checks, such as the 6 MHz strobe implying the 12 MHz one, assume the default parameters, where the 8 MHz tap sits on the first binary stage.

// File: rtl/ce_pkg.sv
package ce_pkg;
  function automatic int ce_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ce_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ce_bin_div.sv
module ce_bin_div #(
  parameter int STAGES  = 3,
  parameter int SRC_TAP = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              tick_src,
  output logic              tick_last,
  output logic [STAGES-1:0] en_q
);
  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] tick;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_tap
      assign tick[i] = &cnt[i:0];
    end
  endgenerate

  assign tick_src  = tick[SRC_TAP];
  assign tick_last = tick[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      en_q <= '0;
    end else begin
      cnt  <= cnt + STAGES'(1);
      en_q <= tick;
    end
  end
endmodule

// File: rtl/ce_div_n.sv
module ce_div_n
  import ce_pkg::*;
#(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic tick_o,
  output logic en_q
);
  localparam int W = ce_width(N);

  logic [W-1:0] cnt;

  assign tick_o = tick_i && (cnt == W'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= tick_o;
      if (tick_i) begin
        cnt <= tick_o ? '0 : cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/ce_main_sel.sv
module ce_main_sel (
  input  logic clk,
  input  logic rst,
  input  logic sel_in,
  input  logic fast_tick,
  input  logic slow_tick,
  output logic en_q
);
  logic sel_q;
  logic boundary;

  assign boundary = fast_tick && slow_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel_in;
      en_q  <= 1'b0;
    end else begin
      en_q <= sel_q ? slow_tick : fast_tick;
      if (boundary) begin
        sel_q <= sel_in;
      end
    end
  end
endmodule

// File: rtl/ce_clock_gen.sv
module ce_clock_gen #(
  parameter int BIN_STAGES = 3,
  parameter int PHI_TAP    = 0,
  parameter int PHI_DIV    = 3,
  parameter int HALF_DIV   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_slow,
  output logic [BIN_STAGES-1:0] en_bin,
  output logic                  en_phi,
  output logic                  en_sound,
  output logic                  en_main
);
  localparam int LEN_FAST = 2 ** BIN_STAGES;
  localparam int LEN_SLOW = (2 ** (PHI_TAP + 1)) * PHI_DIV * HALF_DIV;

  logic phi_src;
  logic fast_tick;
  logic phi_tick;
  logic slow_tick;

  ce_bin_div #(.STAGES(BIN_STAGES), .SRC_TAP(PHI_TAP)) u_bin (
    .clk      (clk),
    .rst      (rst),
    .tick_src (phi_src),
    .tick_last(fast_tick),
    .en_q     (en_bin)
  );

  ce_div_n #(.N(PHI_DIV)) u_phi (
    .clk   (clk),
    .rst   (rst),
    .tick_i(phi_src),
    .tick_o(phi_tick),
    .en_q  (en_phi)
  );

  ce_div_n #(.N(HALF_DIV)) u_snd (
    .clk   (clk),
    .rst   (rst),
    .tick_i(phi_tick),
    .tick_o(slow_tick),
    .en_q  (en_sound)
  );

  ce_main_sel u_main (
    .clk      (clk),
    .rst      (rst),
    .sel_in   (sel_slow),
    .fast_tick(fast_tick),
    .slow_tick(slow_tick),
    .en_q     (en_main)
  );
endmodule

// File: rtl/ce_clock_gen_chk.sv
module ce_clock_gen_chk #(
  parameter int BIN_STAGES = 3,
  parameter int LEN_FAST   = 8,
  parameter int LEN_SLOW   = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic [BIN_STAGES-1:0] en_bin,
  input logic                  en_phi,
  input logic                  en_sound,
  input logic                  en_main
);
  logic        rst_d = 1'b0;
  logic        seen  = 1'b0;
  logic [15:0] gap   = 16'd0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      seen <= 1'b0;
      gap  <= 16'd1;
    end else if (en_main) begin
      seen <= 1'b1;
      gap  <= 16'd1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  // R1: outputs clear after a reset edge
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_clear: assert ((en_bin == '0) && !en_phi && !en_sound && !en_main);
    end
  end

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    en_bin[0] |=> !en_bin[0]);

  generate
    for (genvar i = 1; i < BIN_STAGES; i++) begin : g_nest
      a_r3_tap_nested: assert property (@(posedge clk) disable iff (rst)
        en_bin[i] |-> en_bin[i-1]);
    end
  endgenerate

  a_r4_phi_on_24: assert property (@(posedge clk) disable iff (rst)
    en_phi |-> en_bin[0]);

  a_r5_sound_on_phi: assert property (@(posedge clk) disable iff (rst)
    en_sound |-> en_phi);

  a_r7_main_gap: assert property (@(posedge clk) disable iff (rst)
    (en_main && seen) |-> ((gap == 16'(LEN_FAST)) || (gap == 16'(LEN_SLOW))));
endmodule

bind ce_clock_gen ce_clock_gen_chk #(
  .BIN_STAGES(BIN_STAGES),
  .LEN_FAST  (LEN_FAST),
  .LEN_SLOW  (LEN_SLOW)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .en_bin  (en_bin),
  .en_phi  (en_phi),
  .en_sound(en_sound),
  .en_main (en_main)
);

// File: tb/test_ce_clock_gen.sv
module test_ce_clock_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_slow = 1'b0;
  logic [2:0] en_bin;
  logic       en_phi;
  logic       en_sound;
  logic       en_main;

  int total = 0;
  int bad   = 0;
  int n     = 0;

  // {sel during run, cycles to run}
  localparam logic [8:0] VEC [0:3] = '{9'h030, 9'h130, 9'h01E, 9'h13C};

  always #4 clk = ~clk;

  ce_clock_gen i_ce_clock_gen (
    .clk     (clk),
    .rst     (rst),
    .sel_slow(sel_slow),
    .en_bin  (en_bin),
    .en_phi  (en_phi),
    .en_sound(en_sound),
    .en_main (en_main)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, n, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1;
    sel_slow = s;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1 en_bin0", en_bin[0], 1'b0);
    check("R1 en_bin1", en_bin[1], 1'b0);
    check("R1 en_bin2", en_bin[2], 1'b0);
    check("R1 en_phi", en_phi, 1'b0);
    check("R1 en_sound", en_sound, 1'b0);
    check("R1 en_main", en_main, 1'b0);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic step();
    @(posedge clk);
    n++;
    @(negedge clk);
  endtask

  initial begin
    // table walk: constant jumper, every output against its period
    for (int v = 0; v < 4; v++) begin
      do_reset(VEC[v][8]);
      for (int k = 0; k < int'(VEC[v][7:0]); k++) begin
        step();
        check("R2 en_bin0", en_bin[0], (n % 2) == 0);
        check("R3 en_bin1", en_bin[1], (n % 4) == 0);
        check("R3 en_bin2", en_bin[2], (n % 8) == 0);
        check("R4 en_phi", en_phi, (n % 6) == 0);
        check("R5 en_sound", en_sound, (n % 12) == 0);
        check("R6 en_main", en_main, VEC[v][8] ? ((n % 12) == 0) : ((n % 8) == 0));
      end
    end

    // R7: jumper moved mid-period, fast to slow and back
    do_reset(1'b0);
    while (n < 75) begin
      step();
      if (n == 10) sel_slow = 1'b1;
      if (n == 40) sel_slow = 1'b0;
      check("R7 en_main", en_main,
            (n == 8) || (n == 16) || (n == 24) || (n == 36) ||
            (n == 48) || (n == 56) || (n == 64) || (n == 72));
      check("R5 en_sound", en_sound, (n % 12) == 0);
    end

    // R8: jumper captured in reset, changed as reset is released
    do_reset(1'b1);
    sel_slow = 1'b0;
    while (n < 42) begin
      step();
      check("R8 en_main", en_main, (n == 12) || (n == 24) || (n == 32) || (n == 40));
    end

    // R1: reset asserted in the middle of a run clears everything
    step();
    do_reset(1'b0);
    step();
    check("R1 restart en_bin0", en_bin[0], 1'b0);
    step();
    check("R1 restart en_bin0", en_bin[0], 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule